// File: doc/BRIEF.md
# Tagged Fully-Associative Translation Buffer

This block holds a small set of address translations, each tagged by a virtual page base, a page-size code, a partition number, a context number and a flag that marks the entry as a real (untranslated-space) mapping. Every entry also carries a lock bit, a valid bit, a recently-used bit and an opaque payload holding the physical page and permission bits. A lookup port searches all entries in parallel and reports, one clock later, whether one matched, which one, and its payload.

A command port, one command per clock, inserts new translations and removes old ones. Insert clears any entry that overlaps the new page before writing, then either honours a caller-chosen slot or picks one with a not-recently-used policy that spares locked entries. Removal comes in four strengths: one page, one context, one partition's unlocked entries, or everything. A combinational diagnostic port reads back any slot's packed tag and payload, so software or a test can see exactly what the array holds.

Top module: `tlb_array`

## Requirements
- R1: An entry matches a request when it is valid, its real flag and partition equal the request's, the address lies in its page, and (for non-real entries only) its context equals the request's; lk_hit, lk_idx and lk_data show the result of a request one clock after lk_req is sampled, and lk_hit is 0 in a clock after no request.
- R2: Page sizes are coded 0..3 for 2^(13+3*code) bytes; on insert (cmd_op=1) the stored virtual base is cmd_va with the offset bits of the new page size cleared.
- R3: Insert first invalidates every entry that overlaps the new page under the R1 partition/real/context rule, and clears its used bit, before choosing a slot.
- R4: When ins_force is 1, the insert writes slot ins_idx regardless of its state.
- R5: Without ins_force the slot is the lowest invalid one; failing that the lowest unlocked entry whose used bit is clear; failing that the lowest unlocked entry; failing that the last slot.
- R6: A new entry is written valid and used; whenever an insert or lookup update would leave every used bit set, all used bits are cleared except the one just set.
- R7: A lookup hit with lk_upd=1 in a clock with no command (cmd_op=0) sets the hit entry's used bit; with lk_upd=0 the used bits are left unchanged.
- R8: Demap-page (cmd_op=2) invalidates the entry that a lookup with cmd_va/cmd_pid/cmd_ctx/cmd_real would hit.
- R9: Demap-context (cmd_op=3) invalidates every entry whose partition and context equal cmd_pid and cmd_ctx, locked or not.
- R10: Demap-partition (cmd_op=4) invalidates the unlocked entries whose partition equals cmd_pid, and leaves locked ones and other partitions valid.
- R11: Flush (cmd_op=5) invalidates every entry.
- R12: rd_tag reads all ones for an invalid slot; for a valid slot it packs context in bits 12:0, the virtual base in bits VA_W-1:13, partition in bits 63:61, the real flag in bit 60 and the inverted size code in bits 57:56; rd_data reads the payload, or all ones when invalid.
- R13: After reset all slots are invalid and lk_hit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_op | input | 3 | Command: 0 none, 1 insert, 2 demap page, 3 demap context, 4 demap partition, 5 flush |
| cmd_va | input | VA_W | Virtual address for insert and demap-page |
| cmd_pid | input | PID_W | Partition for the command |
| cmd_ctx | input | CTX_W | Context for the command |
| cmd_real | input | 1 | Real-mapping flag for the command |
| ins_size | input | 2 | Page-size code of the inserted entry |
| ins_lock | input | 1 | Lock bit of the inserted entry |
| ins_force | input | 1 | Use ins_idx as the insert slot |
| ins_idx | input | IW | Forced insert slot |
| ins_data | input | DATA_W | Payload of the inserted entry |
| lk_req | input | 1 | Lookup request |
| lk_va | input | VA_W | Lookup address |
| lk_pid | input | PID_W | Lookup partition |
| lk_ctx | input | CTX_W | Lookup context |
| lk_real | input | 1 | Lookup real flag |
| lk_upd | input | 1 | Let a hit mark its entry used |
| lk_hit | output | 1 | Registered hit |
| lk_idx | output | IW | Registered index of the lowest matching entry |
| lk_data | output | DATA_W | Registered payload of the hit entry |
| rd_idx | input | IW | Diagnostic read slot |
| rd_tag | output | 64 | Packed tag of the slot |
| rd_data | output | DATA_W | Payload of the slot |

## Verification
The bench drives the replacement policy into its awkward corners: a lookup with the update input low ahead of an insert, so a design that marks the entry anyway would pick a different victim; a lookup that fills every used bit, so a design that skips the clearing step would fall back to the first unlocked slot instead of a fresh one. It inserts a larger page over a smaller one while a lower slot is free, so a design that forgets the overlap clear leaves a stale duplicate visible in the diagnostic read. It also separates the demap strengths with a locked entry and a second partition, where a design that mixes up the lock rule either kills the locked entry early or keeps it after the context demap.

// File: rtl/tlb_pkg.sv
// Shared definitions for the translation buffer.
// Assumes page sizes grow by a factor of eight from an 8 KiB base.
package tlb_pkg;

    localparam int BASE_SHIFT = 13;

    typedef enum logic [2:0] {
        OP_NOP        = 3'd0,
        OP_INSERT     = 3'd1,
        OP_DEMAP_PAGE = 3'd2,
        OP_DEMAP_CTX  = 3'd3,
        OP_DEMAP_PART = 3'd4,
        OP_FLUSH      = 3'd5
    } tlb_op_e;

    // Number of offset bits for a page-size code.
    function automatic int page_shift(input logic [1:0] code);
        return BASE_SHIFT + 3 * int'(code);
    endfunction

endpackage

// File: rtl/tlb_match.sv
// Parallel tag comparator. Reports, per entry, whether the entry's page
// and the probe page overlap under the partition/real/context rule.
// A probe size code of 0 reduces this to "address lies inside the page".
// Assumes entry bases are aligned to their own page size.
module tlb_match #(
    parameter int N     = 16,
    parameter int VA_W  = 32,
    parameter int PID_W = 3,
    parameter int CTX_W = 13
) (
    input  logic [N-1:0]            e_valid,
    input  logic [N-1:0]            e_real,
    input  logic [N-1:0][VA_W-1:0]  e_va,
    input  logic [N-1:0][1:0]       e_sz,
    input  logic [N-1:0][PID_W-1:0] e_pid,
    input  logic [N-1:0][CTX_W-1:0] e_ctx,
    input  logic [VA_W-1:0]         p_va,
    input  logic [1:0]              p_sz,
    input  logic [PID_W-1:0]        p_pid,
    input  logic [CTX_W-1:0]        p_ctx,
    input  logic                    p_real,
    output logic [N-1:0]            hit
);
    import tlb_pkg::*;

    localparam logic [VA_W-1:0] ONES = '1;

    logic [VA_W-1:0] p_off;
    assign p_off = ~(ONES << page_shift(p_sz));

    for (genvar g = 0; g < N; g++) begin : g_ent
        logic [VA_W-1:0] e_off;
        logic            range_ok;
        // Offset mask of this entry, then overlap under the larger page.
        always_comb begin
            e_off    = ~(ONES << page_shift(e_sz[g]));
            range_ok = (((e_va[g] ^ p_va) & ~(e_off | p_off)) == '0);
        end
        // Full match: tag fields plus range; context ignored for real pages.
        assign hit[g] = e_valid[g] && (e_real[g] == p_real) &&
                        (e_pid[g] == p_pid) && range_ok &&
                        (p_real || (e_ctx[g] == p_ctx));
    end
endmodule

// File: rtl/tlb_pick.sv
// Lowest-index priority encoder. Assumes N >= 2.
module tlb_pick #(
    parameter int N  = 16,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  cand,
    output logic          found,
    output logic [IW-1:0] idx
);
    // Scan from the top so the lowest set bit is left in idx.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/tlb_victim.sv
// Insert slot selection: forced slot, else lowest invalid, else lowest
// unlocked and not recently used, else lowest unlocked, else the last slot.
// Assumes its inputs already reflect overlap invalidation for this insert.
module tlb_victim #(
    parameter int N  = 16,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  valid,
    input  logic [N-1:0]  used,
    input  logic [N-1:0]  lock,
    input  logic          force_en,
    input  logic [IW-1:0] force_idx,
    output logic [IW-1:0] victim
);
    logic          inv_f, nru_f, unl_f;
    logic [IW-1:0] inv_i, nru_i, unl_i;

    tlb_pick #(.N(N)) u_inv (.cand(~valid),        .found(inv_f), .idx(inv_i));
    tlb_pick #(.N(N)) u_nru (.cand(~used & ~lock), .found(nru_f), .idx(nru_i));
    tlb_pick #(.N(N)) u_unl (.cand(~lock),         .found(unl_f), .idx(unl_i));

    // Apply the preference order.
    always_comb begin
        if (force_en)   victim = force_idx;
        else if (inv_f) victim = inv_i;
        else if (nru_f) victim = nru_i;
        else if (unl_f) victim = unl_i;
        else            victim = IW'(N - 1);
    end
endmodule

// File: rtl/tlb_array.sv
// Fully associative translation buffer with lookup, insert, demap,
// flush and diagnostic read. One command per clock; a lookup runs in
// parallel and its result is registered. A lookup only updates used bits
// in a clock with no command. Assumes 2 <= N_ENTRIES <= 64,
// VA_W in 23..56, PID_W <= 3, CTX_W <= 13.
module tlb_array #(
    parameter int N_ENTRIES = 16,
    parameter int VA_W      = 32,
    parameter int PID_W     = 3,
    parameter int CTX_W     = 13,
    parameter int DATA_W    = 32,
    localparam int IW       = $clog2(N_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cmd_op,
    input  logic [VA_W-1:0]   cmd_va,
    input  logic [PID_W-1:0]  cmd_pid,
    input  logic [CTX_W-1:0]  cmd_ctx,
    input  logic              cmd_real,
    input  logic [1:0]        ins_size,
    input  logic              ins_lock,
    input  logic              ins_force,
    input  logic [IW-1:0]     ins_idx,
    input  logic [DATA_W-1:0] ins_data,
    input  logic              lk_req,
    input  logic [VA_W-1:0]   lk_va,
    input  logic [PID_W-1:0]  lk_pid,
    input  logic [CTX_W-1:0]  lk_ctx,
    input  logic              lk_real,
    input  logic              lk_upd,
    output logic              lk_hit,
    output logic [IW-1:0]     lk_idx,
    output logic [DATA_W-1:0] lk_data,
    input  logic [IW-1:0]     rd_idx,
    output logic [63:0]       rd_tag,
    output logic [DATA_W-1:0] rd_data
);
    import tlb_pkg::*;

    localparam int N = N_ENTRIES;
    localparam logic [VA_W-1:0] ONES = '1;

    logic [N-1:0]             valid_q, used_q, lock_q, real_q;
    logic [N-1:0][VA_W-1:0]   va_q;
    logic [N-1:0][1:0]        sz_q;
    logic [N-1:0][PID_W-1:0]  pid_q;
    logic [N-1:0][CTX_W-1:0]  ctx_q;
    logic [N-1:0][DATA_W-1:0] data_q;

    tlb_op_e         op;
    logic [1:0]      probe_sz;
    logic [VA_W-1:0] va_al;
    logic [N-1:0]    cmd_hit, lk_cand, pid_eq, ctx_eq, clr;
    logic [N-1:0]    valid_clr, used_clr, valid_n, used_n;
    logic [IW-1:0]   vic, lk_i;
    logic            lk_f;

    assign op       = tlb_op_e'(cmd_op);
    assign probe_sz = (op == OP_INSERT) ? ins_size : 2'd0;
    assign va_al    = cmd_va & (ONES << page_shift(ins_size));

    // Probe for insert overlap and demap-page.
    tlb_match #(.N(N), .VA_W(VA_W), .PID_W(PID_W), .CTX_W(CTX_W)) u_cmd_match (
        .e_valid(valid_q), .e_real(real_q), .e_va(va_q), .e_sz(sz_q),
        .e_pid(pid_q), .e_ctx(ctx_q), .p_va(cmd_va), .p_sz(probe_sz),
        .p_pid(cmd_pid), .p_ctx(cmd_ctx), .p_real(cmd_real), .hit(cmd_hit)
    );

    // Probe for the lookup port.
    tlb_match #(.N(N), .VA_W(VA_W), .PID_W(PID_W), .CTX_W(CTX_W)) u_lk_match (
        .e_valid(valid_q), .e_real(real_q), .e_va(va_q), .e_sz(sz_q),
        .e_pid(pid_q), .e_ctx(ctx_q), .p_va(lk_va), .p_sz(2'd0),
        .p_pid(lk_pid), .p_ctx(lk_ctx), .p_real(lk_real), .hit(lk_cand)
    );

    tlb_pick #(.N(N)) u_lk_pick (.cand(lk_cand), .found(lk_f), .idx(lk_i));

    for (genvar g = 0; g < N; g++) begin : g_eq
        assign pid_eq[g] = (pid_q[g] == cmd_pid);
        assign ctx_eq[g] = (ctx_q[g] == cmd_ctx);
    end

    // Entries each command removes.
    always_comb begin
        case (op)
            OP_INSERT, OP_DEMAP_PAGE: clr = cmd_hit;
            OP_DEMAP_CTX:             clr = pid_eq & ctx_eq;
            OP_DEMAP_PART:            clr = pid_eq & ~lock_q;
            OP_FLUSH:                 clr = '1;
            default:                  clr = '0;
        endcase
    end

    assign valid_clr = valid_q & ~clr;
    assign used_clr  = used_q & ~clr;

    tlb_victim #(.N(N)) u_victim (
        .valid(valid_clr), .used(used_clr), .lock(lock_q),
        .force_en(ins_force), .force_idx(ins_idx), .victim(vic)
    );

    // Next valid/used vectors, including the all-used clearing rule.
    always_comb begin
        valid_n = valid_clr;
        used_n  = used_clr;
        if (op == OP_INSERT) begin
            valid_n[vic] = 1'b1;
            used_n[vic]  = 1'b1;
            if (&used_n) begin
                used_n      = '0;
                used_n[vic] = 1'b1;
            end
        end else if (op == OP_NOP && lk_req && lk_upd && lk_f) begin
            used_n[lk_i] = 1'b1;
            if (&used_n) begin
                used_n       = '0;
                used_n[lk_i] = 1'b1;
            end
        end
    end

    // Valid and used state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            used_q  <= '0;
        end else begin
            valid_q <= valid_n;
            used_q  <= used_n;
        end
    end

    // Tag and payload fields, written only by insert.
    always_ff @(posedge clk) begin
        if (rst_n && op == OP_INSERT) begin
            va_q[vic]   <= va_al;
            sz_q[vic]   <= ins_size;
            pid_q[vic]  <= cmd_pid;
            ctx_q[vic]  <= cmd_ctx;
            real_q[vic] <= cmd_real;
            lock_q[vic] <= ins_lock;
            data_q[vic] <= ins_data;
        end
    end

    // Registered lookup result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_hit  <= 1'b0;
            lk_idx  <= '0;
            lk_data <= '0;
        end else begin
            lk_hit  <= lk_req && lk_f;
            lk_idx  <= lk_i;
            lk_data <= (lk_req && lk_f) ? data_q[lk_i] : '0;
        end
    end

    // Diagnostic packing of one slot.
    always_comb begin
        rd_tag                        = '0;
        rd_tag[CTX_W-1:0]             = ctx_q[rd_idx];
        rd_tag[VA_W-1:BASE_SHIFT]     = va_q[rd_idx][VA_W-1:BASE_SHIFT];
        rd_tag[63:64-PID_W]           = pid_q[rd_idx];
        rd_tag[60]                    = real_q[rd_idx];
        rd_tag[57:56]                 = ~sz_q[rd_idx];
        rd_data                       = data_q[rd_idx];
        if (!valid_q[rd_idx]) begin
            rd_tag  = '1;
            rd_data = '1;
        end
    end
endmodule

// File: rtl/tlb_array_chk.sv
// Property checker for tlb_array, bound to every instance.
module tlb_array_chk #(
    parameter int N = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic [2:0]   cmd_op,
    input logic         lk_req,
    input logic         lk_hit,
    input logic [N-1:0] valid_q,
    input logic [N-1:0] used_q,
    input logic [N-1:0] lock_q
);
    p_hit_needs_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(lk_req) |-> !lk_hit);

    p_used_never_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        used_q != {N{1'b1}});

    p_used_only_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (used_q & ~valid_q) == '0);

    p_insert_fills_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_op == 3'd1 |=> valid_q != '0);

    p_locked_survive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_op == 3'd4 |=> (valid_q & lock_q) == $past(valid_q & lock_q));

    p_flush_empties_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_op == 3'd5 |=> valid_q == '0);
endmodule

bind tlb_array tlb_array_chk #(.N(N_ENTRIES)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .lk_req(lk_req),
    .lk_hit(lk_hit), .valid_q(valid_q), .used_q(used_q), .lock_q(lock_q)
);

// File: tb/sim_tlb_array.sv
module sim_tlb_array;
    localparam int N = 4;
    localparam int IW = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [31:0] cmd_va = '0;
    logic [2:0]  cmd_pid = '0;
    logic [12:0] cmd_ctx = '0;
    logic        cmd_real = 1'b0;
    logic [1:0]  ins_size = '0;
    logic        ins_lock = 1'b0;
    logic        ins_force = 1'b0;
    logic [IW-1:0] ins_idx = '0;
    logic [31:0] ins_data = '0;
    logic        lk_req = 1'b0;
    logic [31:0] lk_va = '0;
    logic [2:0]  lk_pid = '0;
    logic [12:0] lk_ctx = '0;
    logic        lk_real = 1'b0;
    logic        lk_upd = 1'b0;
    logic        lk_hit;
    logic [IW-1:0] lk_idx;
    logic [31:0] lk_data;
    logic [IW-1:0] rd_idx = '0;
    logic [63:0] rd_tag;
    logic [31:0] rd_data;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic        hit;
        logic [1:0]  idx;
        logic [31:0] data;
        string       req;
    } exp_t;
    exp_t q[$];
    logic seen = 1'b0;

    always #10 clk = ~clk;

    tlb_array #(.N_ENTRIES(N)) u0 (.*);

    task automatic report(input bit ok, input string req, input logic [63:0] act,
                          input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] etag(input logic [31:0] va, input logic [1:0] sz,
                                         input logic [2:0] pid, input logic [12:0] ctx,
                                         input logic rl);
        logic [63:0] t = '0;
        logic [31:0] base = va & ~((32'd1 << (13 + 3 * sz)) - 32'd1);
        t[12:0]  = ctx;
        t[31:13] = base[31:13];
        t[63:61] = pid;
        t[60]    = rl;
        t[57:56] = ~sz;
        return t;
    endfunction

    task automatic cmd(input logic [2:0] op, input logic [31:0] va, input logic [2:0] pid,
                       input logic [12:0] ctx, input logic rl, input logic [1:0] sz,
                       input logic lk, input logic frc, input logic [1:0] fi,
                       input logic [31:0] d);
        @(negedge clk);
        cmd_op = op; cmd_va = va; cmd_pid = pid; cmd_ctx = ctx; cmd_real = rl;
        ins_size = sz; ins_lock = lk; ins_force = frc; ins_idx = fi; ins_data = d;
        @(negedge clk);
        cmd_op = 3'd0; ins_force = 1'b0;
    endtask

    // Driver: issue one lookup and queue what the scoreboard must see.
    task automatic look(input logic [31:0] va, input logic [2:0] pid, input logic [12:0] ctx,
                        input logic rl, input logic upd, input logic eh, input logic [1:0] ei,
                        input logic [31:0] ed, input string req);
        exp_t e;
        @(negedge clk);
        lk_req = 1'b1; lk_va = va; lk_pid = pid; lk_ctx = ctx; lk_real = rl; lk_upd = upd;
        e.hit = eh; e.idx = ei; e.data = ed; e.req = req;
        q.push_back(e);
        @(negedge clk);
        lk_req = 1'b0; lk_upd = 1'b0;
    endtask

    task automatic tag_is(input logic [1:0] i, input logic [63:0] exp, input string req);
        rd_idx = i;
        #2;
        report(rd_tag === exp, req, rd_tag, exp);
    endtask

    // Monitor: a request sampled at a clock edge is compared at the next falling edge.
    always @(posedge clk) seen <= lk_req;
    always @(negedge clk) begin
        if (seen) begin
            exp_t e;
            if (q.size() == 0) begin
                report(1'b0, "R1 unexpected result", {63'd0, lk_hit}, 64'd0);
            end else begin
                e = q.pop_front();
                if (e.hit)
                    report(lk_hit === 1'b1 && lk_idx === e.idx && lk_data === e.data, e.req,
                           {31'd0, lk_hit, 30'd0, lk_idx, lk_data},
                           {31'd0, 1'b1, 30'd0, e.idx, e.data});
                else
                    report(lk_hit === 1'b0, e.req, {63'd0, lk_hit}, 64'd0);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13: empty after reset
        report(lk_hit === 1'b0, "R13 lk_hit after reset", {63'd0, lk_hit}, 64'd0);
        tag_is(2'd0, '1, "R13 slot0 invalid after reset");
        report(rd_data === '1, "R13 rd_data invalid", {32'd0, rd_data}, {32'd0, 32'hFFFF_FFFF});
        look(32'h5000, 3'd1, 13'd5, 1'b0, 1'b0, 1'b0, 2'd0, 32'd0, "R13 lookup miss when empty");

        // A: slot 0, base aligned down (R2, R5)
        cmd(3'd1, 32'h5123, 3'd1, 13'd5, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 32'hA);
        tag_is(2'd0, etag(32'h5123, 2'd0, 3'd1, 13'd5, 1'b0), "R2 R12 aligned tag of A");
        report(rd_data === 32'hA, "R12 rd_data of A", {32'd0, rd_data}, 64'hA);
        look(32'h5FFF, 3'd1, 13'd5, 1'b0, 1'b0, 1'b1, 2'd0, 32'hA, "R1 hit at page end");
        look(32'h5FFF, 3'd1, 13'd6, 1'b0, 1'b0, 1'b0, 2'd0, 32'd0, "R1 miss other context");
        look(32'h5FFF, 3'd2, 13'd5, 1'b0, 1'b0, 1'b0, 2'd0, 32'd0, "R1 miss other partition");
        look(32'h5FFF, 3'd1, 13'd5, 1'b1, 1'b0, 1'b0, 2'd0, 32'd0, "R1 miss real flag");
        look(32'h6000, 3'd1, 13'd5, 1'b0, 1'b0, 1'b0, 2'd0, 32'd0, "R1 miss next page");

        // B real 64 KiB, C locked, D: all used after D
        cmd(3'd1, 32'h10000, 3'd1, 13'd9, 1'b1, 2'd1, 1'b0, 1'b0, 2'd0, 32'hB);
        look(32'h1ABCD, 3'd1, 13'd3, 1'b1, 1'b0, 1'b1, 2'd1, 32'hB, "R1 real ignores context");
        cmd(3'd1, 32'h20000, 3'd1, 13'd5, 1'b0, 2'd0, 1'b1, 1'b0, 2'd0, 32'hC);
        cmd(3'd1, 32'h30000, 3'd1, 13'd5, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 32'hD);
        tag_is(2'd3, etag(32'h30000, 2'd0, 3'd1, 13'd5, 1'b0), "R5 D in last free slot");

        // E: no invalid slot, first unlocked unused is 0
        cmd(3'd1, 32'h40000, 3'd1, 13'd5, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 32'hE);
        tag_is(2'd0, etag(32'h40000, 2'd0, 3'd1, 13'd5, 1'b0), "R5 R6 E replaces slot 0");
        look(32'h5000, 3'd1, 13'd5, 1'b0, 1'b0, 1'b0, 2'd0, 32'd0, "R5 A gone");

        // Lookup without update must not mark B, so F lands on slot 1
        look(32'h10000, 3'd1, 13'd0, 1'b1, 1'b0, 1'b1, 2'd1, 32'hB, "R7 B hit no update");
        cmd(3'd1, 32'h50000, 3'd1, 13'd5, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 32'hF);
        tag_is(2'd1, etag(32'h50000, 2'd0, 3'd1, 13'd5, 1'b0), "R7 F replaces unmarked B");

        // Lookup C with update fills used bits -> cleared but C; then mark E
        look(32'h20000, 3'd1, 13'd5, 1'b0, 1'b1, 1'b1, 2'd2, 32'hC, "R7 C hit with update");
        look(32'h40000, 3'd1, 13'd5, 1'b0, 1'b1, 1'b1, 2'd0, 32'hE, "R7 E hit with update");
        cmd(3'd1, 32'h70000, 3'd1, 13'd5, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 32'h6);
        tag_is(2'd1, etag(32'h70000, 2'd0, 3'd1, 13'd5, 1'b0), "R6 used reset lets G take slot 1");

        // Forced slot
        cmd(3'd1, 32'h60000, 3'd1, 13'd5, 1'b0, 2'd0, 1'b0, 1'b1, 2'd3, 32'h8);
        tag_is(2'd3, etag(32'h60000, 2'd0, 3'd1, 13'd5, 1'b0), "R4 forced slot 3");

        // Demap page E
        cmd(3'd2, 32'h40100, 3'd1, 13'd5, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 32'd0);
        tag_is(2'd0, '1, "R8 demap page clears slot 0");
        look(32'h40000, 3'd1, 13'd5, 1'b0, 1'b0, 1'b0, 2'd0, 32'd0, "R8 E no longer hits");

        // Larger page over G: G cleared, new entry in slot 0
        cmd(3'd1, 32'h78000, 3'd1, 13'd5, 1'b0, 2'd1, 1'b0, 1'b0, 2'd0, 32'h1);
        tag_is(2'd1, '1, "R3 overlapped G invalidated");
        tag_is(2'd0, etag(32'h78000, 2'd1, 3'd1, 13'd5, 1'b0), "R3 R2 new 64K entry slot 0");
        look(32'h7F000, 3'd1, 13'd5, 1'b0, 1'b0, 1'b1, 2'd0, 32'h1, "R3 single hit on new page");

        // Other partition into slot 1
        cmd(3'd1, 32'h80000, 3'd2, 13'd5, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 32'h2);
        tag_is(2'd1, etag(32'h80000, 2'd0, 3'd2, 13'd5, 1'b0), "R5 J in freed slot 1");

        // Demap partition 1: locked C and partition 2 survive
        cmd(3'd4, 32'd0, 3'd1, 13'd0, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 32'd0);
        tag_is(2'd0, '1, "R10 unlocked slot 0 removed");
        tag_is(2'd3, '1, "R10 unlocked slot 3 removed");
        tag_is(2'd2, etag(32'h20000, 2'd0, 3'd1, 13'd5, 1'b0), "R10 locked C kept");
        tag_is(2'd1, etag(32'h80000, 2'd0, 3'd2, 13'd5, 1'b0), "R10 other partition kept");

        // Demap context removes locked C
        cmd(3'd3, 32'd0, 3'd1, 13'd5, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 32'd0);
        tag_is(2'd2, '1, "R9 locked C removed by context demap");
        tag_is(2'd1, etag(32'h80000, 2'd0, 3'd2, 13'd5, 1'b0), "R9 other partition kept");

        // Flush
        cmd(3'd5, 32'd0, 3'd0, 13'd0, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 32'd0);
        tag_is(2'd1, '1, "R11 flush clears slot 1");
        look(32'h80000, 3'd2, 13'd5, 1'b0, 1'b0, 1'b0, 2'd0, 32'd0, "R11 miss after flush");

        repeat (3) @(negedge clk);
        report(q.size() == 0, "R1 all lookups answered", 64'(q.size()), 64'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule